// File: doc/BRIEF.md
# Memory Access Latency Traffic Generator

This block measures how long a memory-mapped fabric takes to serve one complete transaction. Control logic hands it a descriptor made of a direction (read or write), a start address and a size in bytes, together with a one-cycle start pulse. The block turns the descriptor into one or more INCR bursts on an AXI4 master port. It issues the bursts one after another. Each burst is limited to 256 beats and never crosses a 4 KiB page.

A saturating cycle counter starts on the first address handshake of the transaction. It stops on the handshake that finishes the whole transaction. For a read, that is the last data beat of the final burst. For a write, it is the write response of the final burst. The count is then held on the `latency` output next to a `done` flag and a sticky `err` flag, so software can read it at leisure. Choosing addresses and analysing the results are left to software.

Top module: `lat_probe`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `err` and `latency` are zero, and no valid is raised on the AR, AW or W channels.
- R2: A start pulse seen while idle with a nonzero `cmd_len` is accepted. `busy` reads 1 one cycle later, and `done` and `err` are cleared. A start pulse with `cmd_len` equal to zero is ignored, and the block stays idle.
- R3: Start pulses that arrive while `busy` is high have no effect on the bursts that are issued or on the result.
- R4: A read needs ceil(`cmd_len` / bytes-per-beat) beats. The first burst starts at `cmd_addr`, and each following burst starts where the previous one ended. Every burst has arburst = 01 (INCR) and arsize = log2(bytes per beat). Each burst is as long as possible without exceeding 256 beats, without crossing a 4 KiB page and without exceeding the beats that remain. Only one burst is in flight at a time.
- R5: A write is split into bursts by the same rule as R4, on the AW channel. Its W beats carry the running beat number of the transaction, counting from 0, in `m_wdata`, with all strobes set. `m_wlast` is raised on the final beat of every burst.
- R6: A read completes on the handshake of the beat with `m_rlast` in the final burst. A write completes on the B handshake of the final burst. On that edge `busy` falls and `done` rises.
- R7: `latency` equals the number of rising clock edges from the first address handshake of the transaction up to and including the completing handshake. It holds that value until the next completion.
- R8: When the true latency exceeds 2^CNT_W-1, `latency` reads 2^CNT_W-1 rather than wrapping.
- R9: A read or write response of 10 (SLVERR) or 11 (DECERR) sets `err`. The transaction still runs to completion, and `err` stays set until the next accepted start.
- R10: Once AR or AW valid is raised, it stays high with the address and length unchanged until the ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle start pulse |
| cmd_is_write | input | 1 | 1 = write transaction, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address, aligned to a beat |
| cmd_len | input | LEN_W | Transaction size in bytes |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last measurement finished |
| err | output | 1 | Error response seen in the last measurement |
| latency | output | CNT_W | Measured cycle count |
| m_araddr | output | ADDR_W | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type (INCR) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last read beat of a burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data (running beat number) |
| m_wstrb | output | DATA_W/8 | Write strobes, all set |
| m_wlast | output | 1 | Last write beat of a burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
An accepted start shows as `busy` one cycle later. Address, data and response handshakes take effect on the edge where they happen. `busy`, `done`, `err` and `latency` all change on the completing handshake edge, and their new values are visible from the following falling edge.

The reference model takes its decisions on rising edges from the values present just before that edge. The bench compares all four result outputs against the model on every falling edge, half a cycle after the registers have settled. The expected latency is the difference between the edge counts recorded by the model at the first address handshake and at the completing handshake, clipped to the counter maximum.

// File: rtl/lat_pkg.sv
package lat_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_RESP
   } lat_state_e;

   localparam int unsigned PAGE_BYTES = 4096;
   localparam int unsigned PAGE_OFF_W = 12;
   localparam int unsigned MAX_BEATS  = 256;
   localparam logic [1:0]  BURST_INCR = 2'b01;

   // SLVERR and DECERR count as failures, OKAY and EXOKAY do not
   function automatic logic resp_is_err(input logic [1:0] resp);
      return (resp == 2'b10) || (resp == 2'b11);
   endfunction

endpackage

// File: rtl/lat_burst_calc.sv
module lat_burst_calc import lat_pkg::*; #(
   parameter int unsigned BEAT_SHIFT = 2,
   parameter int unsigned REM_W      = 12
) (
   input  logic [PAGE_OFF_W-1:0] page_off,
   input  logic [REM_W-1:0]      rem_beats,
   output logic [8:0]            burst_beats,
   output logic [7:0]            axlen
);

   localparam int unsigned PG_W = PAGE_OFF_W + 1;
   localparam int unsigned CW   = (REM_W > PG_W) ? REM_W : PG_W;

   logic [PG_W-1:0] to_page;
   logic [CW-1:0]   rem_c;
   logic [CW-1:0]   pg_c;
   logic [CW-1:0]   lim_pg;
   logic [CW-1:0]   lim;

   always_comb begin
      to_page = (PG_W'(PAGE_BYTES) - {1'b0, page_off}) >> BEAT_SHIFT;
      rem_c   = CW'(rem_beats);
      pg_c    = CW'(to_page);
      lim_pg  = (rem_c < pg_c) ? rem_c : pg_c;
   end

   generate
      if ((MAX_BEATS << BEAT_SHIFT) < PAGE_BYTES) begin : g_cap
         always_comb lim = (lim_pg > CW'(MAX_BEATS)) ? CW'(MAX_BEATS) : lim_pg;
      end else begin : g_nocap
         assign lim = lim_pg;
      end
   endgenerate

   assign burst_beats = 9'(lim);
   assign axlen       = 8'(lim - CW'(1));

endmodule

// File: rtl/lat_sat_timer.sv
module lat_sat_timer #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             stop,
   output logic [CNT_W-1:0] count_nxt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             running;
   logic [CNT_W-1:0] count;

   assign count_nxt = (count == CNT_MAX) ? CNT_MAX : count + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         count   <= '0;
      end else if (clear) begin
         running <= 1'b1;
         count   <= '0;
      end else if (running) begin
         count <= count_nxt;
         if (stop) running <= 1'b0;
      end
   end

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !clear && (count == CNT_MAX) |=> (count == CNT_MAX));

endmodule

// File: rtl/lat_probe.sv
module lat_probe import lat_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LEN_W  = 13,
   parameter int unsigned CNT_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_start,
   input  logic                cmd_is_write,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [LEN_W-1:0]    cmd_len,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [CNT_W-1:0]    latency,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [7:0]          m_arlen,
   output logic [2:0]          m_arsize,
   output logic [1:0]          m_arburst,
   output logic                m_arvalid,
   input  logic                m_arready,
   input  logic [1:0]          m_rresp,
   input  logic                m_rlast,
   input  logic                m_rvalid,
   output logic                m_rready,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [7:0]          m_awlen,
   output logic [2:0]          m_awsize,
   output logic [1:0]          m_awburst,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wlast,
   output logic                m_wvalid,
   input  logic                m_wready,
   input  logic [1:0]          m_bresp,
   input  logic                m_bvalid,
   output logic                m_bready
);

   localparam int unsigned BYTES      = DATA_W / 8;
   localparam int unsigned BEAT_SHIFT = $clog2(BYTES);
   localparam int unsigned REM_W      = LEN_W + 1 - BEAT_SHIFT;

   generate
      if ((DATA_W < 8) || ((1 << $clog2(DATA_W)) != DATA_W)) begin : g_bad_data
         $error("DATA_W must be a power of two of at least 8");
      end
      if (ADDR_W < PAGE_OFF_W) begin : g_bad_addr
         $error("ADDR_W must cover a 4 KiB page offset");
      end
      if (LEN_W <= BEAT_SHIFT) begin : g_bad_len
         $error("LEN_W must exceed the beat size code");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   lat_state_e       state;
   logic             is_wr;
   logic             final_burst;
   logic             first_hs;
   logic             done_q;
   logic             err_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [REM_W-1:0] rem_beats;
   logic [REM_W-1:0] wbeat_no;
   logic [8:0]       beats_left;
   logic [CNT_W-1:0] lat_q;
   logic [CNT_W-1:0] tmr_nxt;
   logic [8:0]       burst_beats;
   logic [7:0]       axlen;
   logic [LEN_W:0]   len_up;
   logic [REM_W-1:0] start_beats;

   logic accept, addr_hs, r_hs, w_hs, b_hs, finish;

   assign len_up      = {1'b0, cmd_len} + (LEN_W+1)'(BYTES - 1);
   assign start_beats = REM_W'(len_up >> BEAT_SHIFT);

   lat_burst_calc #(
      .BEAT_SHIFT (BEAT_SHIFT),
      .REM_W      (REM_W)
   ) i_calc (
      .page_off    (cur_addr[PAGE_OFF_W-1:0]),
      .rem_beats   (rem_beats),
      .burst_beats (burst_beats),
      .axlen       (axlen)
   );

   assign accept  = (state == ST_IDLE) && cmd_start && (cmd_len != '0);
   assign addr_hs = (m_arvalid && m_arready) || (m_awvalid && m_awready);
   assign r_hs    = m_rvalid && m_rready;
   assign w_hs    = m_wvalid && m_wready;
   assign b_hs    = m_bvalid && m_bready;
   assign finish  = final_burst && ((r_hs && m_rlast) || b_hs);

   lat_sat_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (addr_hs && first_hs),
      .stop      (finish),
      .count_nxt (tmr_nxt)
   );

   assign m_araddr  = cur_addr;
   assign m_arlen   = axlen;
   assign m_arsize  = 3'(BEAT_SHIFT);
   assign m_arburst = BURST_INCR;
   assign m_arvalid = (state == ST_ADDR) && !is_wr;
   assign m_rready  = (state == ST_DATA) && !is_wr;
   assign m_awaddr  = cur_addr;
   assign m_awlen   = axlen;
   assign m_awsize  = 3'(BEAT_SHIFT);
   assign m_awburst = BURST_INCR;
   assign m_awvalid = (state == ST_ADDR) && is_wr;
   assign m_wdata   = DATA_W'(wbeat_no);
   assign m_wstrb   = '1;
   assign m_wlast   = (beats_left == 9'd1);
   assign m_wvalid  = (state == ST_DATA) && is_wr;
   assign m_bready  = (state == ST_RESP);

   assign busy    = (state != ST_IDLE);
   assign done    = done_q;
   assign err     = err_q;
   assign latency = lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         is_wr       <= 1'b0;
         final_burst <= 1'b0;
         first_hs    <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         cur_addr    <= '0;
         rem_beats   <= '0;
         wbeat_no    <= '0;
         beats_left  <= '0;
         lat_q       <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               is_wr     <= cmd_is_write;
               cur_addr  <= cmd_addr;
               rem_beats <= start_beats;
               wbeat_no  <= '0;
               first_hs  <= 1'b1;
               done_q    <= 1'b0;
               err_q     <= 1'b0;
               state     <= ST_ADDR;
            end
            ST_ADDR: if (addr_hs) begin
               cur_addr    <= cur_addr + (ADDR_W'(burst_beats) << BEAT_SHIFT);
               rem_beats   <= rem_beats - REM_W'(burst_beats);
               beats_left  <= burst_beats;
               final_burst <= (REM_W'(burst_beats) == rem_beats);
               first_hs    <= 1'b0;
               state       <= ST_DATA;
            end
            ST_DATA: if (!is_wr) begin
               if (r_hs) begin
                  if (resp_is_err(m_rresp)) err_q <= 1'b1;
                  if (m_rlast) state <= final_burst ? ST_IDLE : ST_ADDR;
               end
            end else if (w_hs) begin
               wbeat_no   <= wbeat_no + 1'b1;
               beats_left <= beats_left - 9'd1;
               if (m_wlast) state <= ST_RESP;
            end
            ST_RESP: if (b_hs) begin
               if (resp_is_err(m_bresp)) err_q <= 1'b1;
               state <= final_burst ? ST_IDLE : ST_ADDR;
            end
            default: state <= ST_IDLE;
         endcase
         if (finish) begin
            done_q <= 1'b1;
            lat_q  <= tmr_nxt;
         end
      end
   end

   // R10
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

   // R10
   aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

   // R4
   page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> (14'(m_araddr[PAGE_OFF_W-1:0])
                     + (14'(m_arlen) + 14'd1) * 14'(BYTES)) <= 14'(PAGE_BYTES));

   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !cmd_start |=> done && $stable(latency));

endmodule

// File: tb/test_lat_probe.sv
module test_lat_probe;

   localparam int AW   = 32;
   localparam int DW   = 32;
   localparam int LW   = 13;
   localparam int CW   = 10;
   localparam int BY   = DW / 8;
   localparam int LMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 1'b0;
   logic cmd_is_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [LW-1:0] cmd_len = '0;
   logic busy, done, err;
   logic [CW-1:0] latency;
   logic [AW-1:0] araddr, awaddr;
   logic [7:0] arlen, awlen;
   logic [2:0] arsize, awsize;
   logic [1:0] arburst, awburst;
   logic arvalid, awvalid, wvalid, wlast, rready, bready;
   logic [DW-1:0] wdata;
   logic [BY-1:0] wstrb;
   logic arready = 1'b0, awready = 1'b0, wready = 1'b0;
   logic rvalid = 1'b0, rlast = 1'b0, bvalid = 1'b0;
   logic [1:0] rresp = 2'b00, bresp = 2'b00;

   always #2 clk = ~clk;

   lat_probe #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) i_lat_probe (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_write(cmd_is_write),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .done(done), .err(err),
      .latency(latency), .m_araddr(araddr), .m_arlen(arlen), .m_arsize(arsize),
      .m_arburst(arburst), .m_arvalid(arvalid), .m_arready(arready), .m_rresp(rresp),
      .m_rlast(rlast), .m_rvalid(rvalid), .m_rready(rready), .m_awaddr(awaddr),
      .m_awlen(awlen), .m_awsize(awsize), .m_awburst(awburst), .m_awvalid(awvalid),
      .m_awready(awready), .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast),
      .m_wvalid(wvalid), .m_wready(wready), .m_bresp(bresp), .m_bvalid(bvalid),
      .m_bready(bready));

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   // reference model and slave state
   bit m_busy = 0, m_done = 0, m_err = 0, m_first = 0;
   int m_lat = 0, t0 = 0;
   logic [AW-1:0] qa[$];
   int qn[$];
   int cur_n = 0, w_idx = 0, w_total = 0;
   int rd_left = 0, rd_wait = 0, b_wait = 0;
   bit b_pend = 0;
   int rd_lat = 3, b_lat = 2;
   bit inj_rerr = 0, inj_berr = 0;
   bit ar_wait = 0, aw_wait = 0;
   logic [AW-1:0] ar_prev = '0, aw_prev = '0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic build(input logic [AW-1:0] addr, input int len);
      longint a = addr;
      int rem = (len + BY - 1) / BY;
      while (rem > 0) begin
         int tp = (4096 - int'(a % 4096)) / BY;
         int n = rem;
         if (tp < n) n = tp;
         if (n > 256) n = 256;
         qa.push_back(AW'(a));
         qn.push_back(n);
         a += n * BY;
         rem -= n;
      end
   endtask

   task automatic addr_seen(input bit wr, input logic [AW-1:0] a, input logic [7:0] l,
                            input logic [2:0] sz, input logic [1:0] bt);
      if (qa.size() == 0) begin
         chk(0, "R3 unexpected burst", a, 0);
      end else begin
         logic [AW-1:0] ea = qa.pop_front();
         int n = qn.pop_front();
         chk(a == ea, wr ? "R5 burst address" : "R4 burst address", a, ea);
         chk(int'(l) == n - 1, wr ? "R5 burst length" : "R4 burst length", l, n - 1);
         chk(sz == 3'd2 && bt == 2'b01, "R4 size and type", {sz, bt}, 5'b01001);
         if (m_first) begin
            t0 = cyc;
            m_first = 0;
         end
         cur_n = n;
         w_idx = 0;
         if (!wr) begin
            rd_left = n;
            rd_wait = rd_lat;
         end
      end
   endtask

   task automatic finish_m();
      m_busy = 0;
      m_done = 1;
      m_lat = (cyc - t0 > LMAX) ? LMAX : cyc - t0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_lat = 0;
         qa.delete(); qn.delete();
         rd_left = 0; b_pend = 0; ar_wait = 0; aw_wait = 0;
      end else begin
         cyc++;
         if (ar_wait) chk(arvalid && araddr == ar_prev, "R10 AR held", araddr, ar_prev);
         if (aw_wait) chk(awvalid && awaddr == aw_prev, "R10 AW held", awaddr, aw_prev);
         ar_wait = arvalid && !arready;
         ar_prev = araddr;
         aw_wait = awvalid && !awready;
         aw_prev = awaddr;
         if (cmd_start && !m_busy && cmd_len != 0) begin
            m_busy = 1; m_done = 0; m_err = 0; m_first = 1; w_total = 0;
            build(cmd_addr, int'(cmd_len));
         end
         if (arvalid && arready) addr_seen(0, araddr, arlen, arsize, arburst);
         if (awvalid && awready) addr_seen(1, awaddr, awlen, awsize, awburst);
         if (rvalid && rready) begin
            rd_left--;
            if (rresp >= 2'b10) m_err = 1;
            if (rlast && qa.size() == 0) finish_m();
         end
         if (wvalid && wready) begin
            chk(int'(wdata) == w_total, "R5 data", wdata, w_total);
            chk(wlast == (w_idx == cur_n - 1), "R5 last", wlast, w_idx == cur_n - 1);
            chk(wstrb == '1, "R5 strobes", wstrb, 15);
            w_total++;
            w_idx++;
            if (wlast) begin
               b_pend = 1;
               b_wait = b_lat;
            end
         end
         if (bvalid && bready) begin
            b_pend = 0;
            if (bresp >= 2'b10) m_err = 1;
            if (qa.size() == 0) finish_m();
         end
         if (rd_wait > 0) rd_wait--;
         if (b_wait > 0) b_wait--;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, "R6 busy", busy, m_busy);
         chk(done == m_done, "R6 done", done, m_done);
         chk(err == m_err, "R9 err", err, m_err);
         chk(int'(latency) == m_lat, "R7 latency", latency, m_lat);
      end
      arready = (cyc % 3) != 1;
      awready = (cyc % 2) == 0;
      wready  = (cyc % 4) != 3;
      rvalid  = rd_left > 0 && rd_wait == 0 && (cyc % 5) != 4;
      rlast   = rd_left == 1;
      rresp   = (inj_rerr && rd_left == 1) ? 2'b10 : 2'b00;
      bvalid  = b_pend && b_wait == 0;
      bresp   = inj_berr ? 2'b11 : 2'b00;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic issue(input bit wr, input logic [AW-1:0] a, input int len);
      cmd_is_write = wr;
      cmd_addr = a;
      cmd_len = LW'(len);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic run(input bit wr, input logic [AW-1:0] a, input int len);
      issue(wr, a, len);
      wait_idle();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !err && latency == 0, "R1 results", {busy, done, err}, 0);
      chk(!arvalid && !awvalid && !wvalid, "R1 channels", {arvalid, awvalid, wvalid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 after release", {busy, done}, 0);

      run(0, 32'h1000, 64);                    // R4 single burst
      chk(done && latency > 0, "R6 read done", done, 1);
      run(1, 32'h2000, 128);                   // R5 single burst
      run(0, 32'h1FF0, 64);                    // R4 page split
      run(0, 32'h3000, 4096);                  // R4 256-beat cap
      run(1, 32'h0FFC, 8);                     // R5 page split
      run(1, 32'h4000, 6);                     // R4 rounding up

      // R2: zero length ignored
      issue(0, 32'h5000, 0);
      chk(!busy && !arvalid, "R2 zero length", busy, 0);
      chk(done, "R2 result kept", done, 1);

      // R3: start while busy
      issue(0, 32'h6000, 32);
      chk(busy, "R2 busy after start", busy, 1);
      issue(1, 32'h7000, 16);
      wait_idle();
      repeat (3) @(negedge clk);
      chk(!busy && !awvalid, "R3 second start ignored", busy, 0);

      // R9: error responses
      inj_berr = 1;
      run(1, 32'h8000, 16);
      chk(err, "R9 write error", err, 1);
      inj_berr = 0;
      inj_rerr = 1;
      run(0, 32'h8100, 16);
      chk(err, "R9 read error", err, 1);
      inj_rerr = 0;
      run(0, 32'h8200, 16);
      chk(!err, "R9 cleared", err, 0);

      // R8: saturation
      rd_lat = 1100;
      run(0, 32'h9000, 4);
      chk(int'(latency) == LMAX, "R8 saturate", latency, LMAX);
      rd_lat = 1;
      run(0, 32'hA000, 4);
      chk(int'(latency) == m_lat && latency < 10, "R7 short read", latency, m_lat);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule